// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It derives a converter clock from the CPU clock, drives a sample switch, steps a DAC code through a binary search one bit at a time from the most significant bit down, reads back a one-bit comparator decision per step, and stores the finished code in two byte-wide data registers. The analog side (input selector, hold capacitor, comparator) lives outside. The block sees it only through `chan_o`, `sample_o`, `dac_o` and `cmp_i`.

Software drives the block through a small register port. Reads are combinational on `addr_i`. Writes and read side effects take place at the clock edge where `wr_i` or `rd_i` is high. Address 0 is the control/status register. Address 1 holds the upper eight result bits. Address 2 holds the lower two result bits and a clock-slowdown bit. Address 3 reads as zero. Once the converter is switched on, it converts again and again for as long as it stays on.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The control register at address 0 has these fields: channel in bits [2:0], enable in bit 3, fast in bit 4, and the read-only done flag in bit 7. Bits 5 and 6 read as zero. `chan_o` always equals the stored channel.
- R2: Address 1 reads result[9:2]. Address 2 reads result[1:0] in bits [1:0] and the slow bit in bit 5, and its other bits read as zero. Bit 5 of a write to address 2 sets the slow bit.
- R3: The converter clock is one tick every 2 CPU clocks when fast=1 and slow=0. For every other combination it is one tick every 4 CPU clocks.
- R4: Each conversion spends 4 ticks in a sample phase with `sample_o` high. It then spends 10 ticks in the approximation phase. There, `dac_o` shows the code built so far with the current trial bit added, from bit 9 down, and the trial bit is kept when `cmp_i` is high. The done flag becomes visible exactly 14 ticks after the starting write.
- R5: An input at or above full scale gives 3FFh, which reads as FFh at address 1 and 03h in bits [1:0] of address 2. An input below zero gives 000h.
- R6: A control write with enable=1 while the converter is off starts a conversion. Conversions then repeat back to back. A control write with enable=0 stops the converter at once, with `sample_o` low and `dac_o` zero, and no further result is latched.
- R7: The done flag sets when a result is latched. It clears on any control write and on a read (`rd_i`) of address 2. If a latch and a clear fall on the same edge, the set wins.
- R8: A control write that changes the channel while the converter is on aborts the current conversion and restarts the sample phase on the new channel. The timing of R4 is then counted from that write.
- R9: Both data registers change only at the edge where a result is latched, so the two halves always come from the same conversion.
- R10: After reset all registers read zero, the converter is off and `sample_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (used for the side effect of the read) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| chan_o | output | 3 | Selected analog channel |
| sample_o | output | 1 | Sample switch enable |
| dac_o | output | 10 | Trial code to the DAC |
| cmp_i | input | 1 | Comparator: input at or above the DAC level |

## Verification
The bench counts CPU clocks from the starting write until the done flag is visible, for each clock setting. A divider that mapped speed and slow wrongly, or a sample phase of the wrong length, would be off by whole ticks. It drives inputs above full scale and below zero, which a search with a bad keep/clear rule or an off-by-one bit order would turn into a wrong code. It changes the channel mid-conversion and then changes the input between latches. A design that did not restart would report the old channel's value too early, and one that exposed its working register would show a half-built code between results. It also checks that reading the low register clears the flag while reading the high one does not.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int unsigned REG_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;

  localparam int unsigned CTRL_EN_BIT   = 3;
  localparam int unsigned CTRL_FAST_BIT = 4;
  localparam int unsigned CTRL_DONE_BIT = 7;
  localparam int unsigned LO_SLOW_BIT   = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned DIV_FAST = 2,
  parameter int unsigned DIV_SLOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(DIV_SLOW);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fast_i ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign tick_o = !clear_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (cnt_q >= lim)    cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R3: fast division never gives two ticks in a row
  a_r3_fast_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && fast_i && !clear_i) |=> !tick_o);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_pkg::*;
#(
  parameter int unsigned RES_W     = 10,
  parameter int unsigned SMP_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             halt_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic             latch_o,
  output logic [RES_W-1:0] final_o
);
  localparam int unsigned SW = (SMP_TICKS > 1) ? $clog2(SMP_TICKS) : 1;

  seq_state_e       state_q;
  logic [SW-1:0]    smp_q;
  logic [RES_W-1:0] mask_q, acc_q, trial;
  logic             step;

  assign trial    = acc_q | mask_q;
  assign step     = tick_i && !restart_i && !halt_i;
  assign sample_o = (state_q == ST_SAMPLE);
  assign dac_o    = (state_q == ST_CONV) ? trial : '0;
  assign final_o  = cmp_i ? trial : acc_q;
  assign latch_o  = step && (state_q == ST_CONV) && mask_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      smp_q   <= '0;
      mask_q  <= '0;
      acc_q   <= '0;
    end else if (restart_i) begin
      state_q <= ST_SAMPLE;
      smp_q   <= '0;
      mask_q  <= '0;
      acc_q   <= '0;
    end else if (halt_i) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      acc_q   <= '0;
    end else if (step) begin
      case (state_q)
        ST_SAMPLE: begin
          if (smp_q == SW'(SMP_TICKS - 1)) begin
            state_q <= ST_CONV;
            mask_q  <= {1'b1, {(RES_W-1){1'b0}}};
            acc_q   <= '0;
          end else begin
            smp_q <= smp_q + 1'b1;
          end
        end
        ST_CONV: begin
          acc_q  <= final_o;
          mask_q <= mask_q >> 1;
          if (mask_q[0]) begin
            state_q <= ST_SAMPLE;
            smp_q   <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: exactly one trial bit during approximation
  a_r4_one_trial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> $onehot(mask_q));
  // R8: restart lands in the sample phase at its first tick
  a_r8_restart_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (sample_o && smp_q == '0));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import adc_pkg::*;
#(
  parameter int unsigned RES_W     = 10,
  parameter int unsigned CH_W      = 3,
  parameter int unsigned SMP_TICKS = 4,
  parameter int unsigned DIV_FAST  = 2,
  parameter int unsigned DIV_SLOW  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  input  logic             cmp_i
);
  localparam int unsigned LO_W = RES_W - REG_W;

  logic [CH_W-1:0]  chan_q;
  logic             en_q, fast_q, slow_q, done_q;
  logic [RES_W-1:0] data_q;

  logic wr_ctrl, wr_lo, rd_lo, restart, halt, tick, latch;
  logic [RES_W-1:0] final_code;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_lo   = wr_i && (addr_i == ADDR_LO);
  assign rd_lo   = rd_i && (addr_i == ADDR_LO);
  assign restart = wr_ctrl && wdata_i[CTRL_EN_BIT] &&
                   (!en_q || (wdata_i[CH_W-1:0] != chan_q));
  assign halt    = !en_q || (wr_ctrl && !wdata_i[CTRL_EN_BIT]);
  assign chan_o  = chan_q;

  adc_clk_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart || halt),
    .fast_i  (fast_q && !slow_q),
    .tick_o  (tick)
  );

  adc_sar_seq #(.RES_W(RES_W), .SMP_TICKS(SMP_TICKS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .halt_i    (halt),
    .tick_i    (tick),
    .cmp_i     (cmp_i),
    .sample_o  (sample_o),
    .dac_o     (dac_o),
    .latch_o   (latch),
    .final_o   (final_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      en_q   <= 1'b0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) begin
        chan_q <= wdata_i[CH_W-1:0];
        en_q   <= wdata_i[CTRL_EN_BIT];
        fast_q <= wdata_i[CTRL_FAST_BIT];
      end
      if (wr_lo) slow_q <= wdata_i[LO_SLOW_BIT];
      if (latch) begin
        data_q <= final_code;
        done_q <= 1'b1;
      end else if (wr_ctrl || rd_lo) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CH_W-1:0]     = chan_q;
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_FAST_BIT] = fast_q;
        rdata_o[CTRL_DONE_BIT] = done_q;
      end
      ADDR_HI: rdata_o = data_q[RES_W-1 -: REG_W];
      ADDR_LO: begin
        rdata_o[LO_W-1:0]   = data_q[LO_W-1:0];
        rdata_o[LO_SLOW_BIT] = slow_q;
      end
      default: rdata_o = '0;
    endcase
  end

  // R9: result halves move only together, at a latch
  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch |=> $stable(data_q));
  // R7: a latch always leaves the flag set
  a_r7_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> done_q);
  // R6: converter off means analog side quiet
  a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!sample_o && dac_o == '0));
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] chan;
  logic       sample;
  logic [9:0] dac;
  logic       cmp;
  int         vin [8];
  int         errors = 0, checks = 0;

  always #4 clk = ~clk;

  always_comb cmp = (vin[chan] >= int'({22'd0, dac}));

  sar_adc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .chan_o(chan), .sample_o(sample),
    .dac_o(dac), .cmp_i(cmp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  task automatic rd_pulse(input logic [1:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; addr = 2'd0;
  endtask

  // called right after wr_reg: counts edges since the write edge
  task automatic wait_done(output int n);
    int d;
    n = 0;
    forever begin
      peek(2'd0, d);
      if (d[7] || n > 2000) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    int d;
    peek(2'd0, d); chk("R10 ctrl", d, 0);
    peek(2'd1, d); chk("R10 hi", d, 0);
    peek(2'd2, d); chk("R10 lo", d, 0);
    chk("R10 sample", int'(sample), 0);
  endtask

  task automatic t_basic;
    int n, d;
    vin[2] = 613;
    wr_reg(2'd0, 8'h1A);
    chk("R4 sample high", int'(sample), 1);
    repeat (7) @(negedge clk);
    chk("R4 still sampling", int'(sample), 1);
    @(negedge clk);
    chk("R4 msb trial", int'(dac), 512);
    wait_done(n);
    chk("R3 fast period", n + 8, 28);
    peek(2'd1, d); chk("R2 hi", d, 613 >> 2);
    peek(2'd2, d); chk("R2 lo", d, 613 & 3);
    peek(2'd0, d); chk("R1 ctrl", d, 8'h9A);
    chk("R1 chan_o", int'(chan), 2);
  endtask

  task automatic t_slow;
    int n, d;
    wr_reg(2'd2, 8'h20);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd0, 8'h1A);
    wait_done(n);
    chk("R3 fast+slow period", n, 56);
    peek(2'd2, d); chk("R2 slow bit", d, 8'h20 | (613 & 3));
    wr_reg(2'd2, 8'hDF);
    peek(2'd2, d); chk("R2 slow cleared", d, 613 & 3);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd0, 8'h0A);
    wait_done(n);
    chk("R3 slow period", n, 56);
  endtask

  task automatic t_sat;
    int n, d;
    wr_reg(2'd0, 8'h00);
    vin[3] = 5000;
    wr_reg(2'd0, 8'h1B);
    wait_done(n);
    peek(2'd1, d); chk("R5 over hi", d, 8'hFF);
    peek(2'd2, d); chk("R5 over lo", d, 3);
    wr_reg(2'd0, 8'h00);
    vin[3] = -7;
    wr_reg(2'd0, 8'h1B);
    wait_done(n);
    peek(2'd1, d); chk("R5 under hi", d, 0);
    peek(2'd2, d); chk("R5 under lo", d, 0);
  endtask

  task automatic t_eoc_repeat;
    int n, d;
    wr_reg(2'd0, 8'h00);
    vin[4] = 300;
    wr_reg(2'd0, 8'h1C);
    wait_done(n);
    rd_pulse(2'd1);
    peek(2'd0, d); chk("R7 hi read keeps flag", d >> 7, 1);
    rd_pulse(2'd2);
    peek(2'd0, d); chk("R7 lo read clears", d >> 7, 0);
    vin[4] = 777;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      peek(2'd1, d);
      if (d != (300 >> 2)) begin chk("R9 hi held", d, 300 >> 2); break; end
    end
    n = 0;
    forever begin
      peek(2'd0, d);
      if (d[7] || n > 100) break;
      @(negedge clk); n++;
    end
    chk("R6 repeats", d >> 7, 1);
    peek(2'd1, d); chk("R9 new hi", d, 777 >> 2);
    peek(2'd2, d); chk("R9 new lo", d, 777 & 3);
    wr_reg(2'd0, 8'h1C);
    peek(2'd0, d); chk("R7 ctrl write clears", d >> 7, 0);
  endtask

  task automatic t_chan;
    int n, d;
    wr_reg(2'd0, 8'h00);
    vin[1] = 100; vin[5] = 900;
    wr_reg(2'd0, 8'h19);
    repeat (10) @(negedge clk);
    wr_reg(2'd0, 8'h1D);
    wait_done(n);
    chk("R8 restart period", n, 28);
    peek(2'd1, d); chk("R8 new chan hi", d, 900 >> 2);
    peek(2'd2, d); chk("R8 new chan lo", d, 900 & 3);
  endtask

  task automatic t_stop;
    int d, seen;
    wr_reg(2'd0, 8'h05);
    chk("R6 stop sample", int'(sample), 0);
    chk("R6 stop dac", int'(dac), 0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      peek(2'd0, d);
      if (d[7] || sample) seen = 1;
    end
    chk("R6 no conversion when off", seen, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_slow;
    t_sat;
    t_eoc_repeat;
    t_chan;
    t_stop;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule